// File: doc/BRIEF.md
# Serial Port Host Register File

This block is the processor-facing register set of a classic byte-wide serial port. A host reaches eight byte registers through a small address, a write strobe and a read strobe. The registers cover receive and transmit data, the baud divisor, interrupt enable and identification, line control, modem control, line status, modem status and scratch.

The bit-level shifter and the baud generator sit outside the block. Bytes written for transmission leave through a valid/ready handshake. Received bytes arrive on a single-cycle valid input. The block keeps a hidden transmit-interrupt-pending flag. That flag, and not the raw holding-register-empty status, drives the transmit interrupt, and reading the identification register clears it. A loopback bit in modem control makes modem-status reads reflect the modem-control outputs.

Read data is combinational from the current register state. Read side effects take place at the clock edge that ends the read strobe.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the line status reads 0x60, the identification reads 0x01, irq is low and tx_valid is low.
- R2: Only addr bits 2:0 select a register, so addr 0x0F reaches the same register as offset 7 (scratch).
- R3: When line-control bit 7 is set, offset 0 and offset 1 read and write the low and high bytes of the divisor, shown on `divisor`, and a write to offset 0 starts no transmission.
- R4: A write to offset 0 with line-control bit 7 clear raises tx_valid with that byte on tx_data, and clears line-status bit 5 (holding empty) and bit 6 (transmitter empty). The byte and tx_valid hold steady while tx_ready is low.
- R5: In the cycle after tx_valid and tx_ready are both high, tx_valid drops, line-status bits 5 and 6 are set, and the transmit-pending flag is set.
- R6: The identification at offset 2 reads 0x04 when line-status bit 0 and enable bit 0 (offset 1) are both set. Otherwise it reads 0x02 when transmit-pending and enable bit 1 are set. Otherwise it reads 0x01.
- R7: A read of offset 2 that returns 0x02 clears transmit-pending, so the next identification read gives the next lower condition. A read that returns 0x04 leaves transmit-pending set.
- R8: irq is high exactly when the identification value has bit 0 clear.
- R9: rx_valid stores rx_data and sets line-status bit 0. A read of offset 0 with line-control bit 7 clear returns the byte and clears bit 0.
- R10: With modem-control bit 4 clear, offset 6 reads {modem_in, 4'b0000}. With bit 4 set, it reads modem-control bits 3:2 in bits 7:6, bit 0 in bit 5 and bit 1 in bit 4, and all other bits are 0.
- R11: Line control (8 bits), modem control (bits 4:0), interrupt enable (bits 3:0) and scratch read back as written. Writes to offsets 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address, low 3 bits decoded |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| modem_in | input | 4 | Modem inputs {carrier, ring, set-ready, clear-to-send} |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle: irq agrees with bit 0 of every identification read, a pending transmit byte holds still until it is accepted, an accepted byte withdraws tx_valid, a received byte sets data-ready, an identification read of 0x02 clears the pending flag, and loopback reads follow modem control. Other behaviour shows only in the bench's scenarios. These cover the interrupt priority when receive and transmit conditions overlap, the divisor path in place of transmission, the aliasing of the upper address bits, ignored writes to the read-only offsets, and the reset values.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic [3:0]        modem_in,
  output logic [15:0]       divisor,
  output logic              irq
);
  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_THR  = 8'h02;
  localparam logic [7:0] ID_RX   = 8'h04;

  logic [2:0] a;
  logic       unused_hi;
  logic [7:0] div_lo, div_hi, lcr, scr, rbr, tx_hold;
  logic [3:0] ier;
  logic [4:0] mcr;
  logic       data_rdy, thre, temt, thr_pend;
  logic [7:0] iir, lsr, msr_view;
  logic       dlab, wr_thr, rd_rbr, rd_iir;

  assign a         = addr[2:0];
  assign unused_hi = ^addr[ADDR_W-1:3];
  assign dlab      = lcr[7];
  assign wr_thr    = wr_en && a == 3'd0 && !dlab;
  assign rd_rbr    = rd_en && a == 3'd0 && !dlab;
  assign rd_iir    = rd_en && a == 3'd2;
  assign divisor   = {div_hi, div_lo};
  assign tx_data   = tx_hold;
  assign lsr       = {1'b0, temt, thre, 4'b0000, data_rdy};
  assign msr_view  = mcr[4] ? {mcr[3:2], mcr[0], mcr[1], 4'b0000} : {modem_in, 4'b0000};
  assign irq       = ~iir[0];

  always_comb begin
    if (data_rdy && ier[0])      iir = ID_RX;
    else if (thr_pend && ier[1]) iir = ID_THR;
    else                         iir = ID_NONE;
  end

  always_comb begin
    case (a)
      3'd0:    rdata = dlab ? div_lo : rbr;
      3'd1:    rdata = dlab ? div_hi : {4'b0000, ier};
      3'd2:    rdata = iir;
      3'd3:    rdata = lcr;
      3'd4:    rdata = {3'b000, mcr};
      3'd5:    rdata = lsr;
      3'd6:    rdata = msr_view;
      default: rdata = scr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo <= '0; div_hi <= '0; lcr <= '0; scr <= '0; rbr <= '0;
      tx_hold <= '0; ier <= '0; mcr <= '0;
      data_rdy <= 1'b0; thre <= 1'b1; temt <= 1'b1; thr_pend <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      if (wr_en) begin
        case (a)
          3'd0: if (dlab) div_lo <= wdata; else tx_hold <= wdata;
          3'd1: if (dlab) div_hi <= wdata; else ier <= wdata[3:0];
          3'd3: lcr <= wdata;
          3'd4: mcr <= wdata[4:0];
          3'd7: scr <= wdata;
          default: ;
        endcase
      end
      if (wr_thr) begin
        tx_valid <= 1'b1; thre <= 1'b0; temt <= 1'b0; thr_pend <= 1'b0;
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0; thre <= 1'b1; temt <= 1'b1; thr_pend <= 1'b1;
      end else if (rd_iir && iir == ID_THR) begin
        thr_pend <= 1'b0;
      end
      if (rx_valid) begin
        rbr <= rx_data; data_rdy <= 1'b1;
      end else if (rd_rbr) begin
        data_rdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] a,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       irq,
  input logic       dlab,
  input logic [4:0] mcr,
  input logic       data_rdy,
  input logic       thr_pend
);
  logic thr_wr;
  assign thr_wr = wr_en && a == 3'd0 && !dlab;

  assert_irq_matches_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == 3'd2) |-> (irq == !rdata[0]));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data)));

  assert_tx_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !thr_wr) |=> (!tx_valid && thr_pend));

  assert_rx_sets_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> data_rdy);

  assert_id_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == 3'd2 && rdata == 8'h02 && !thr_wr && !(tx_valid && tx_ready)) |=> !thr_pend);

  assert_loopback_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == 3'd6 && mcr[4]) |-> (rdata[3:0] == 4'h0 && rdata[7] == mcr[3] && rdata[6] == mcr[2]
                                        && rdata[5] == mcr[0] && rdata[4] == mcr[1]));
endmodule

bind uart_regfile uart_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .a(addr[2:0]), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .irq(irq), .dlab(lcr[7]), .mcr(mcr), .data_rdy(data_rdy), .thr_pend(thr_pend)
);

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [3:0]  modem_in = '0;
  logic [15:0] divisor;
  logic        irq;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  uart_regfile #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .modem_in(modem_in), .divisor(divisor), .irq(irq)
  );

  always @(negedge clk) begin
    #2;
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: read addr 0x%02h got 0x%02h expected 0x%02h", t, addr, rdata, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    addr = ad; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = ad; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    rd(8'h05, 8'h60, "R1 lsr");
    rd(8'h02, 8'h01, "R1 iir");

    wr(8'h0F, 8'hA5);
    rd(8'h07, 8'hA5, "R2 alias write");
    rd(8'h3F, 8'hA5, "R2 alias read");

    wr(8'h03, 8'h03);
    rd(8'h03, 8'h03, "R11 lcr");
    wr(8'h04, 8'h1F);
    rd(8'h04, 8'h1F, "R11 mcr");
    wr(8'h04, 8'h00);
    wr(8'h05, 8'h00);
    wr(8'h02, 8'hFF);
    rd(8'h05, 8'h60, "R11 lsr ignores write");
    rd(8'h02, 8'h01, "R11 iir ignores write");

    wr(8'h03, 8'h83);
    wr(8'h00, 8'h34);
    wr(8'h01, 8'h12);
    #1;
    chk("R3 divisor", divisor, 16'h1234);
    chk("R3 no transmit", tx_valid, 0);
    rd(8'h00, 8'h34, "R3 div lo");
    rd(8'h01, 8'h12, "R3 div hi");
    wr(8'h03, 8'h03);
    rd(8'h05, 8'h60, "R3 lsr untouched");

    wr(8'h01, 8'h02);
    rd(8'h01, 8'h02, "R11 ier");
    wr(8'h00, 8'h5A);
    #1;
    chk("R4 tx_valid", tx_valid, 1);
    chk("R4 tx_data", tx_data, 8'h5A);
    rd(8'h05, 8'h00, "R4 lsr busy");
    rd(8'h02, 8'h01, "R4 iir no pending");
    repeat (3) @(negedge clk);
    #1;
    chk("R4 held valid", tx_valid, 1);
    chk("R4 held data", tx_data, 8'h5A);
    chk("R8 irq low", irq, 0);

    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    #1;
    chk("R5 tx_valid low", tx_valid, 0);
    chk("R8 irq high", irq, 1);
    rd(8'h05, 8'h60, "R5 lsr empty");
    rd(8'h02, 8'h02, "R6 thr id");
    rd(8'h02, 8'h01, "R7 cleared");
    #1;
    chk("R8 irq after clear", irq, 0);

    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hC3;
    @(negedge clk); rx_valid = 1'b0;
    rd(8'h05, 8'h61, "R9 data ready");
    rd(8'h02, 8'h01, "R6 rx disabled");
    wr(8'h01, 8'h03);
    rd(8'h02, 8'h04, "R6 rx id");
    @(negedge clk); tx_ready = 1'b1;
    wr(8'h00, 8'h11);
    repeat (2) @(negedge clk);
    tx_ready = 1'b0;
    rd(8'h02, 8'h04, "R6 rx over thr");
    rd(8'h02, 8'h04, "R7 rx read keeps pending");
    rd(8'h00, 8'hC3, "R9 rbr");
    rd(8'h05, 8'h60, "R9 ready cleared");
    rd(8'h02, 8'h02, "R7 thr after rx");
    rd(8'h02, 8'h01, "R7 thr cleared");

    modem_in = 4'b0011;
    wr(8'h04, 8'h0F);
    rd(8'h06, 8'h30, "R10 normal msr");
    wr(8'h04, 8'h16);
    rd(8'h06, 8'h50, "R10 loop a");
    wr(8'h04, 8'h19);
    rd(8'h06, 8'hA0, "R10 loop b");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule